// File: doc/BRIEF.md
# Programmable Per-Channel Input Debouncer

This block is a bank of glitch filters placed in front of the lower-numbered interrupt inputs of an interrupt controller. Each input is first passed through a two-stage synchroniser. On a filtered channel that is enabled and set to level sensitivity, a change reaches the output only after the synchronised input has held its new value for a selectable number of timebase ticks. On a channel that is disabled or set to edge sensitivity, and on every channel above the filtered range, the synchronised input reaches the output one register later.

Software configures each filtered channel through one byte, and four such bytes share a 32-bit word. The byte holds an enable bit, a restart bit and a 3-bit period select. There are three address aliases for the same storage. One is a read-only view, one sets every bit written as 1, and one clears every bit written as 1. Writing a 1 to the restart bit through the set alias clears the channel's stability counter and freezes its output for a short settling window. Firmware does this after it services each debounced event. The period steps grow non-linearly, from half a millisecond up to a quarter of a second. Each step is expressed in units of `TICKS_PER_UNIT` ticks of the `tick` enable, so one unit stands for 500 µs.

Top module: `db_bank`

## Requirements
- R1: After reset every output is 0 and every configuration byte reads 0.
- R2: Address bits [11:8] select the alias: 0x5 is the view, 0x6 is set and 0x7 is clear. A write to the set alias ORs the written 1s into the enable and select bits, a write to the clear alias removes them, and a write to the view changes nothing. All three aliases read back the current configuration.
- R3: The restart bit (byte bit 1) always reads 0.
- R4: Channel n owns byte n mod 4 of the word at address bits [7:2] = n/4. Within that byte, bit 0 is enable, bit 1 is restart and bits [6:4] are the period select. Bits 2, 3 and 7 read 0, and words with no channel read 0.
- R5: When filtering is not in effect, the output equals the input as it was three clock edges earlier (two synchroniser stages plus one register).
- R6: When filtering is in effect, the output takes the synchronised input's value on the tick that completes the selected number of ticks during which that input has differed from the output, and it never changes on a clock without a tick.
- R7: If the synchronised input returns to the output value before the count completes, the count restarts from zero.
- R8: Select codes 0 through 7 give periods of 1, 2, 32, 64, 128, 256, 512 and 512 units of `TICKS_PER_UNIT` ticks (500 µs up to 256 ms). Code 7 equals code 6.
- R9: Channels at or above `NUM_DB` have no configuration byte: their byte reads 0, writes to it are ignored, and their output is always the unfiltered path of R5.
- R10: Filtering is in effect only when both the enable bit and `lvl_mode[n]` are 1.
- R11: A set-alias write with the restart bit clears the counter and loads a settling window of `RST_TICKS` ticks. While the window runs on an enabled channel, the output holds and no count accumulates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one pulse per tick |
| lvl_mode | input | NUM_IN | 1 = channel set to level sensitivity |
| din | input | NUM_IN | Raw asynchronous inputs |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address: [11:8] alias, [7:2] word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| dout | output | NUM_IN | Filtered outputs |

## Verification
The hardest situation to reach is a restart that arrives partway through a count on an enabled channel. If it comes too early, the settling window expires before anything was pending. If it comes too late, the output has already flipped. The stimulus toggles the input, waits for a known number of ticks shorter than the period, and then issues the restart write. A behavioural per-channel model tracks the counter, the window and the synchroniser history, and the outputs are compared with it on every clock. Long periods (codes 6 and 7) are held in full with gapped ticks, so that the no-tick hold is exercised at the same time.

// File: rtl/db_pkg.sv
package db_pkg;
    localparam logic [3:0] ALIAS_VIEW = 4'h5;
    localparam logic [3:0] ALIAS_SET  = 4'h6;
    localparam logic [3:0] ALIAS_CLR  = 4'h7;
    localparam int unsigned MAX_UNITS = 512;

    typedef struct packed {
        logic       en;
        logic [2:0] sel;
    } cfg_t;

    // Stable period in 500 us units for each select code.
    function automatic int unsigned sel_units(logic [2:0] s);
        case (s)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 32;
            3'd3:    return 64;
            3'd4:    return 128;
            3'd5:    return 256;
            default: return MAX_UNITS;
        endcase
    endfunction
endpackage

// File: rtl/db_cfg_regs.sv
module db_cfg_regs import db_pkg::*; #(
    parameter int NUM_DB = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output cfg_t [NUM_DB-1:0]       cfg,
    output logic [NUM_DB-1:0]       rst_req,
    output logic [31:0]             rdata
);
    typedef struct packed {
        cfg_t [NUM_DB-1:0] cfg;
    } state_t;

    state_t st_d, st_q;
    logic [3:0] alias_sel;
    logic [5:0] word_sel;

    assign alias_sel = bus_addr[11:8];
    assign word_sel  = bus_addr[7:2];

    always_comb begin
        st_d    = st_q;
        rst_req = '0;
        rdata   = '0;
        for (int ch = 0; ch < NUM_DB; ch++) begin
            if (word_sel == 6'(ch / 4)) begin
                if (alias_sel == ALIAS_VIEW || alias_sel == ALIAS_SET || alias_sel == ALIAS_CLR)
                    rdata[8*(ch%4) +: 8] = {1'b0, st_q.cfg[ch].sel, 3'b000, st_q.cfg[ch].en};
                if (bus_wr && alias_sel == ALIAS_SET) begin
                    st_d.cfg[ch].en  = st_q.cfg[ch].en  | bus_wdata[8*(ch%4)];
                    st_d.cfg[ch].sel = st_q.cfg[ch].sel | bus_wdata[8*(ch%4)+4 +: 3];
                    rst_req[ch]      = bus_wdata[8*(ch%4)+1];
                end
                if (bus_wr && alias_sel == ALIAS_CLR) begin
                    st_d.cfg[ch].en  = st_q.cfg[ch].en  & ~bus_wdata[8*(ch%4)];
                    st_d.cfg[ch].sel = st_q.cfg[ch].sel & ~bus_wdata[8*(ch%4)+4 +: 3];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

    for (genvar ch = 0; ch < NUM_DB; ch++) begin : g_chk
        // R2: a set write with the enable bit leaves the channel enabled
        a_r2_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && alias_sel == ALIAS_SET && word_sel == 6'(ch / 4) && bus_wdata[8*(ch%4)])
            |=> cfg[ch].en);
        // R2: a clear write with the enable bit leaves the channel disabled
        a_r2_clear_disables: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && alias_sel == ALIAS_CLR && word_sel == 6'(ch / 4) && bus_wdata[8*(ch%4)])
            |=> !cfg[ch].en);
    end
endmodule

// File: rtl/db_chan_filter.sv
module db_chan_filter import db_pkg::*; #(
    parameter int TICKS_PER_UNIT = 2,
    parameter int RST_TICKS      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       din_s,
    input  logic       en_eff,
    input  logic [2:0] sel,
    input  logic       rst_req,
    output logic       dout
);
    localparam int MAX_TICKS = int'(MAX_UNITS) * TICKS_PER_UNIT;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam int BW        = $clog2(RST_TICKS + 1);

    typedef struct packed {
        logic          out;
        logic [CW-1:0] cnt;
        logic [BW-1:0] busy;
    } state_t;

    state_t st_d, st_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_inc;

    assign limit   = CW'(sel_units(sel) * TICKS_PER_UNIT);
    assign cnt_inc = st_q.cnt + CW'(1);

    always_comb begin
        st_d = st_q;
        if (!en_eff) begin
            st_d.out = din_s;
            st_d.cnt = '0;
        end else if (st_q.busy != '0) begin
            st_d.cnt = '0;
        end else if (din_s == st_q.out) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (cnt_inc >= limit) begin
                st_d.out = din_s;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
        if (rst_req)
            st_d.busy = BW'(RST_TICKS);
        else if (tick && st_q.busy != '0)
            st_d.busy = st_q.busy - BW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.out;

    // R6: no output change on a filtered channel without a tick
    a_r6_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && !tick) |=> $stable(dout));
    // R6: the counter never exceeds the longest period
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(MAX_TICKS));
    // R7: a matching input restarts the count
    a_r7_match_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && st_q.busy == '0 && din_s == dout) |=> st_q.cnt == '0);
    // R11: output frozen while the settling window runs
    a_r11_freeze_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (en_eff && st_q.busy != '0) |=> $stable(dout));
endmodule

// File: rtl/db_bank.sv
module db_bank import db_pkg::*; #(
    parameter int NUM_IN         = 8,
    parameter int NUM_DB         = 6,
    parameter int TICKS_PER_UNIT = 2,
    parameter int RST_TICKS      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_IN-1:0] lvl_mode,
    input  logic [NUM_IN-1:0] din,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_IN-1:0] dout
);
    typedef struct packed {
        logic [NUM_IN-1:0] s1;
        logic [NUM_IN-1:0] s2;
        logic [NUM_IN-1:0] thru;
    } state_t;

    state_t st_d, st_q;
    cfg_t [NUM_DB-1:0] cfg;
    logic [NUM_DB-1:0] rst_req;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = din;
        st_d.s2   = st_q.s1;
        st_d.thru = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    db_cfg_regs #(.NUM_DB(NUM_DB)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cfg       (cfg),
        .rst_req   (rst_req),
        .rdata     (bus_rdata)
    );

    for (genvar ch = 0; ch < NUM_IN; ch++) begin : g_ch
        if (ch < NUM_DB) begin : g_filt
            db_chan_filter #(
                .TICKS_PER_UNIT (TICKS_PER_UNIT),
                .RST_TICKS      (RST_TICKS)
            ) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick),
                .din_s   (st_q.s2[ch]),
                .en_eff  (cfg[ch].en & lvl_mode[ch]),
                .sel     (cfg[ch].sel),
                .rst_req (rst_req[ch]),
                .dout    (dout[ch])
            );
        end else begin : g_thru
            assign dout[ch] = st_q.thru[ch];
        end
    end
endmodule

// File: tb/db_bank_tb.sv
module db_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NIN = 8;
    localparam int NDB = 6;
    localparam int TPU = 2;
    localparam int RT  = 3;

    logic clk = 0, rst_n = 0, tick = 0, bus_wr = 0;
    logic [NIN-1:0] lvl_mode = '1, din = '0, dout;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;

    int nvec = 0, nbad = 0, cyc = 0, tick_div = 1;
    string tag = "R1";

    int m_s1[NIN], m_s2[NIN], m_out[NIN], m_cnt[NIN], m_busy[NIN];
    int m_cfg[NDB];

    db_bank #(.NUM_IN(NIN), .NUM_DB(NDB), .TICKS_PER_UNIT(TPU), .RST_TICKS(RT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .lvl_mode(lvl_mode), .din(din),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dout(dout));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int period_ticks(int code);
        int u;
        case (code)
            0: u = 1; 1: u = 2; 2: u = 32; 3: u = 64;
            4: u = 128; 5: u = 256; default: u = 512;
        endcase
        return u * TPU;
    endfunction

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NIN; c++) begin
                m_s1[c] = 0; m_s2[c] = 0; m_out[c] = 0; m_cnt[c] = 0; m_busy[c] = 0;
            end
            for (int c = 0; c < NDB; c++) m_cfg[c] = 0;
        end else begin
            for (int c = 0; c < NIN; c++) begin
                bit on;
                on = (c < NDB) && m_cfg[c][0] && lvl_mode[c];
                if (!on) begin
                    m_out[c] = m_s2[c]; m_cnt[c] = 0;
                end else if (m_busy[c] > 0 || m_s2[c] == m_out[c]) begin
                    m_cnt[c] = 0;
                end else if (tick) begin
                    if (m_cnt[c] + 1 >= period_ticks((m_cfg[c] >> 4) & 7)) begin
                        m_out[c] = m_s2[c]; m_cnt[c] = 0;
                    end else m_cnt[c]++;
                end
            end
            for (int c = 0; c < NDB; c++) begin
                int b;
                bit hit;
                hit = bus_wr && (bus_addr[7:2] == c / 4);
                b = (bus_wdata >> (8 * (c % 4))) & 8'hFF;
                if (hit && bus_addr[11:8] == 4'h6 && b[1]) m_busy[c] = RT;
                else if (tick && m_busy[c] > 0) m_busy[c]--;
                if (hit && bus_addr[11:8] == 4'h6) m_cfg[c] = m_cfg[c] | (b & 8'h71);
                if (hit && bus_addr[11:8] == 4'h7) m_cfg[c] = m_cfg[c] & ~(b & 8'h71);
            end
            for (int c = 0; c < NIN; c++) begin
                m_s2[c] = m_s1[c]; m_s1[c] = din[c];
            end
        end
    end

    function automatic logic [31:0] exp_word(logic [3:0] al, int w);
        logic [31:0] r = '0;
        if (al >= 4'h5 && al <= 4'h7)
            for (int c = 0; c < NDB; c++)
                if (c / 4 == w) r[8*(c%4) +: 8] = 8'(m_cfg[c]);
        return r;
    endfunction

    task automatic step();
        logic [NIN-1:0] e;
        @(negedge clk);
        for (int c = 0; c < NIN; c++) e[c] = m_out[c][0];
        nvec++;
        if (dout !== e) begin
            nbad++;
            $display("FAIL %s cycle %0d dout act=%b exp=%b", tag, cyc, dout, e);
        end
        cyc++;
        tick = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [3:0] al, int w, logic [31:0] d);
        bus_addr = {al, 6'(w), 2'b00}; bus_wdata = d; bus_wr = 1;
        step();
        bus_wr = 0;
    endtask

    task automatic rd(logic [3:0] al, int w, string t);
        logic [31:0] e;
        bus_addr = {al, 6'(w), 2'b00};
        #1;
        e = exp_word(al, w);
        nvec++;
        if (bus_rdata !== e) begin
            nbad++;
            $display("FAIL %s read alias %h word %0d act=%h exp=%h", t, al, w, bus_rdata, e);
        end
    endtask

    task automatic toggle_run(logic [NIN-1:0] m, int hold, int times);
        for (int i = 0; i < times; i++) begin
            din = din ^ m;
            idle(hold);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nbad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        idle(3);
        rst_n = 1;
        idle(2);
        rd(4'h5, 0, "R1");
        rd(4'h5, 1, "R1");

        // R2 R3 R4: aliases, field layout, restart reads 0
        tag = "R2";
        wr(4'h6, 0, 32'hFFFF_FFFF);
        rd(4'h5, 0, "R4");           // expect 0x71 per byte, R3 bit 1 clear
        rd(4'h6, 0, "R3");
        wr(4'h7, 0, 32'h0000_00F0);  // clear select of ch0 only
        rd(4'h7, 0, "R2");
        wr(4'h7, 0, 32'hFFFF_FFFF);
        wr(4'h5, 0, 32'hFFFF_FFFF);  // view write ignored
        rd(4'h5, 0, "R2");
        wr(4'h6, 1, 32'hFFFF_FFFF);  // R9: lanes 2,3 of word 1 have no channel
        rd(4'h5, 1, "R9");
        rd(4'h5, 2, "R4");
        rd(4'h3, 0, "R4");
        wr(4'h7, 1, 32'hFFFF_FFFF);
        idle(4);

        // R5: no filtering, three-edge latency
        tag = "R5";
        for (int i = 0; i < 40; i++) begin
            din = din ^ NIN'((i * 37 + 11) & 8'hFF);
            step();
        end

        // R6: periods of codes 0..3 on ch0..3
        tag = "R6";
        wr(4'h6, 0, 32'h3121_1101);
        toggle_run(8'h0F, 150, 6);
        tick_div = 3;
        toggle_run(8'h05, 40, 4);
        tick_div = 1;

        // R7: bounces shorter than the period restart the count
        tag = "R7";
        toggle_run(8'h0C, 20, 10);
        toggle_run(8'h0C, 3, 6);
        idle(200);

        // R8: codes 4..7 including 7 equal to 6
        tag = "R8";
        wr(4'h7, 0, 32'hFFFF_FFFF);
        wr(4'h6, 0, 32'h0000_5141);
        wr(4'h6, 1, 32'h0000_7161);
        rd(4'h5, 1, "R8");
        toggle_run(8'h33, 1100, 2);
        tick_div = 2;
        toggle_run(8'h30, 2100, 1);
        tick_div = 1;

        // R10: level sensitivity gates the filter
        tag = "R10";
        lvl_mode[0] = 0;
        toggle_run(8'h01, 2, 10);
        lvl_mode[0] = 1;
        idle(300);

        // R9: channels above the filtered range always pass through
        tag = "R9";
        wr(4'h6, 1, 32'hFFFF_FFFF);
        rd(4'h6, 1, "R9");
        toggle_run(8'hC0, 2, 10);

        // R11: restart mid-count clears the counter and freezes the output
        tag = "R11";
        wr(4'h7, 0, 32'hFFFF_FFFF);
        wr(4'h6, 0, 32'h0000_0021);   // ch0 code 2: 64 ticks
        idle(10);
        din[0] = ~din[0];
        idle(40);
        wr(4'h6, 0, 32'h0000_0002);
        rd(4'h5, 0, "R3");
        idle(100);
        din[0] = ~din[0];
        idle(60);
        tick_div = 2;
        wr(4'h6, 0, 32'h0000_0002);
        idle(3);
        din[0] = ~din[0];
        idle(200);
        tick_div = 1;

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule